// File: doc/BRIEF.md
# Single-Region Write-Back Buffer Cache

This block turns the processor's one-region on-chip buffer into a cache with a single line, placed in front of a non-volatile main memory. The line holds one aligned region of 128 sixteen-bit words, together with its region tag, a valid bit and a dirty bit. Loads and stores that fall inside the held region finish in the cycle they are presented, and never touch the memory. Stores build up in the buffer, so the costly whole-region commit to memory happens only when a dirty line is displaced or when a flush is requested.

On the processor side, `req` is held together with `we`, `addr` and `wdata` until `stall` drops. In the cycle where `stall` is low, a load's word is on `rdata` and a store takes effect at the clock edge.

On the memory side, the block fills a line by reading one word per cycle, which takes 128 cycles. It writes a line back by streaming the 128 words of the region and then holding the write slot until the commit pulse, so a write-back lasts 512 cycles in total. The `flush` input forces the write-back of a dirty line, so that persistent state can be made safe on demand.

Top module: `region_cache`

## Requirements
- R1: After reset, `valid` and `dirty` are clear, `busy` is low, and no memory enable is active. The first access always misses.
- R2: A load whose address bits [15:7] match the valid held tag returns the buffered word on `rdata` in the same cycle, with `stall` low and no memory access.
- R3: A store hit writes `wdata` into the buffer at the clock edge, with `stall` low and no memory access. It marks the line dirty, and a later load of that address returns the stored value.
- R4: A miss on a clean or invalid line stalls for exactly 129 cycles. It issues 128 word reads of the new region at ascending addresses from offset 0 to 127, and no write.
- R5: A miss on a dirty line first writes back the old region. Its 128 words go out on `mem_wr_en` at ascending addresses, and `mem_commit` pulses on the 512th write-back cycle. The fill then follows, for 641 stalled cycles in total. The written data is what the buffer held.
- R6: When the fill completes, the pending request is served from the buffer. A load returns the new word. A store patches the word and leaves the line dirty, so that the next eviction writes it back.
- R7: `flush` sampled while idle with a dirty line raises `busy` for exactly 512 cycles. During that time the region is written back and committed, and the line ends clean: a following miss performs no write-back.
- R8: `flush` with a clean or invalid line has no effect: `busy` stays low and no memory write occurs.
- R9: The tag is address bits [15:7]. Addresses that differ only in bits [6:0] of the held region all hit, including offsets 0 and 127. Offset 0 of the next region misses.
- R10: `mem_rd_en` and `mem_wr_en` are never high together, and both stay low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Access request, held until stall is low |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | 16 | Word address |
| wdata | input | 16 | Store data |
| rdata | output | 16 | Load data, valid when req is high and stall is low |
| stall | output | 1 | Request cannot complete this cycle |
| flush | input | 1 | Request write-back of a dirty line |
| busy | output | 1 | Write-back or fill in progress |
| mem_rd_en | output | 1 | Word read this cycle |
| mem_rd_addr | output | 16 | Read word address |
| mem_rd_data | input | 16 | Read word, returned in the same cycle |
| mem_wr_en | output | 1 | Word of the region being written back |
| mem_wr_addr | output | 16 | Write word address |
| mem_wr_data | output | 16 | Write word data |
| mem_commit | output | 1 | Last cycle of the region commit |

## Verification
The assertions check the following on every cycle:
- the two memory enables never overlap, and the memory ports are quiet whenever the block is idle;
- a fill is never entered straight from idle while the line is dirty;
- a store hit always leaves the line dirty;
- a completed write-back always leaves it clean;
- a finished fill always validates the line.

Only the bench's scenarios can show the end-to-end results: the exact stall counts of 0, 129 and 641 cycles, the word order and address range of the fills, the timing of the commit pulse, that evicted or flushed data reaches memory intact, that a flush on a clean line does nothing, and that a reset discards a dirty line.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } rc_state_e;
endpackage

// File: rtl/rc_reset_sync.sv
module rc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rc_line_store.sv
module rc_line_store #(
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 128,
  localparam int IDX_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] wb_rdata
);
  logic [DATA_W-1:0] words_q [LINE_WORDS];

  // one register per word, each with its own clock enable
  for (genvar gi = 0; gi < LINE_WORDS; gi++) begin : g_word
    logic              fill_hit;
    logic              cpu_hit;
    logic              word_en;
    logic [DATA_W-1:0] word_d;

    always_comb begin
      fill_hit = fill_we && (fill_idx == IDX_W'(gi));
      cpu_hit  = cpu_we  && (cpu_idx  == IDX_W'(gi));
      word_en  = fill_hit || cpu_hit;
      word_d   = fill_hit ? fill_data : cpu_wdata;
    end

    always_ff @(posedge clk) begin
      if (word_en) words_q[gi] <= word_d;
    end
  end

  assign cpu_rdata = words_q[cpu_idx];
  assign wb_rdata  = words_q[wb_idx];

  // R3: a store never lands while the fill owns the write path
  assert_single_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_we && cpu_we));
endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
  import rc_pkg::*;
#(
  parameter int LINE_WORDS = 128,
  parameter int WB_CYCLES  = 512,
  parameter int TAG_W      = 9,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             flush,
  output rc_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [TAG_W-1:0] pend_tag_o,
  output logic             hit_o,
  output logic             store_hit_o
);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(LINE_WORDS - 1);
  localparam logic [CNT_W-1:0] WB_LAST   = CNT_W'(WB_CYCLES - 1);

  rc_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [TAG_W-1:0] pend_q, pend_d;
  logic             valid_q, valid_d;
  logic             dirty_q, dirty_d;
  logic             refill_q, refill_d;
  logic             hit, store_hit;

  assign hit       = valid_q && (tag_q == req_tag);
  assign store_hit = (state_q == ST_IDLE) && req && we && hit;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    tag_d    = tag_q;
    pend_d   = pend_q;
    valid_d  = valid_q;
    dirty_d  = dirty_q;
    refill_d = refill_q;
    unique case (state_q)
      ST_IDLE: begin
        if (store_hit) dirty_d = 1'b1;
        if (req && !hit) begin
          pend_d = req_tag;
          cnt_d  = '0;
          if (valid_q && dirty_q) begin
            state_d  = ST_WB;
            refill_d = 1'b1;
          end else begin
            state_d = ST_FILL;
            valid_d = 1'b0;
          end
        end else if (flush && valid_q && (dirty_q || store_hit)) begin
          state_d  = ST_WB;
          refill_d = 1'b0;
          cnt_d    = '0;
        end
      end
      ST_WB: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == WB_LAST) begin
          cnt_d   = '0;
          dirty_d = 1'b0;
          if (refill_q) begin
            state_d = ST_FILL;
            valid_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_FILL: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == FILL_LAST) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
          tag_d   = pend_q;
          valid_d = 1'b1;
          dirty_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      tag_q    <= '0;
      pend_q   <= '0;
      valid_q  <= 1'b0;
      dirty_q  <= 1'b0;
      refill_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      tag_q    <= tag_d;
      pend_q   <= pend_d;
      valid_q  <= valid_d;
      dirty_q  <= dirty_d;
      refill_q <= refill_d;
    end
  end

  assign state_o     = state_q;
  assign cnt_o       = cnt_q;
  assign tag_o       = tag_q;
  assign pend_tag_o  = pend_q;
  assign hit_o       = hit;
  assign store_hit_o = store_hit;

  // R5: a fill is never started directly from idle over a dirty line
  assert_no_skip_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && $past(state_q) == ST_IDLE) |-> !$past(dirty_q));
  // R3: a store hit leaves the line dirty
  assert_store_marks_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_hit |=> dirty_q);
  // R7: a finished write-back leaves the line clean
  assert_wb_cleans_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB && cnt_q == WB_LAST) |=> !dirty_q);
  // R4: the last fill word validates the line and returns to idle
  assert_fill_validates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && cnt_q == FILL_LAST) |=> (valid_q && state_q == ST_IDLE));
endmodule

// File: rtl/region_cache.sv
module region_cache
  import rc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 128,
  parameter int WB_CYCLES  = 512,
  localparam int IDX_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = ADDR_W - IDX_W,
  localparam int CNT_W     = $clog2(WB_CYCLES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              stall,
  input  logic              flush,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_commit
);
  localparam logic [CNT_W-1:0] WB_LAST    = CNT_W'(WB_CYCLES - 1);
  localparam logic [CNT_W-1:0] LINE_COUNT = CNT_W'(LINE_WORDS);

  logic             rst_sync_n;
  rc_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [TAG_W-1:0] tag, pend_tag;
  logic             hit, store_hit;
  logic [IDX_W-1:0] step_idx;

  rc_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  rc_ctrl #(
    .LINE_WORDS(LINE_WORDS), .WB_CYCLES(WB_CYCLES), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .req(req), .we(we),
    .req_tag(addr[ADDR_W-1:IDX_W]), .flush(flush),
    .state_o(state), .cnt_o(cnt), .tag_o(tag), .pend_tag_o(pend_tag),
    .hit_o(hit), .store_hit_o(store_hit)
  );

  assign step_idx = cnt[IDX_W-1:0];

  rc_line_store #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_line (
    .clk(clk), .rst_n(rst_sync_n),
    .fill_we(state == ST_FILL), .fill_idx(step_idx), .fill_data(mem_rd_data),
    .cpu_we(store_hit), .cpu_idx(addr[IDX_W-1:0]), .cpu_wdata(wdata),
    .wb_idx(step_idx), .cpu_rdata(rdata), .wb_rdata(mem_wr_data)
  );

  assign stall       = req && !(state == ST_IDLE && hit);
  assign busy        = (state != ST_IDLE);
  assign mem_rd_en   = (state == ST_FILL);
  assign mem_rd_addr = {pend_tag, step_idx};
  assign mem_wr_en   = (state == ST_WB) && (cnt < LINE_COUNT);
  assign mem_wr_addr = {tag, step_idx};
  assign mem_commit  = (state == ST_WB) && (cnt == WB_LAST);

  // R10: the two memory directions never overlap
  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_rd_en && mem_wr_en));
  // R10: the memory ports are quiet whenever the block is idle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> !(mem_rd_en || mem_wr_en || mem_commit));
  // R5: after a commit the block either ends or continues with a fill
  assert_commit_then_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_commit |=> (!busy || mem_rd_en));
endmodule

// File: tb/region_cache_tb.sv
module region_cache_tb;
  localparam int MEMW = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we, flush;
  logic [15:0] addr, wdata;
  logic [15:0] rdata;
  logic        stall, busy;
  logic        mem_rd_en, mem_wr_en, mem_commit;
  logic [15:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;

  logic [15:0] mem     [MEMW];
  logic [15:0] ref_mem [MEMW];

  int total = 0;
  int bad = 0;
  int rd_words = 0;
  int wr_words = 0;
  int commits = 0;
  int cyc = 0;
  int wb_start = 0;
  logic prev_rd = 1'b0;
  logic prev_wr = 1'b0;
  logic [15:0] prev_rd_addr = '0;
  logic [15:0] prev_wr_addr = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  region_cache u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .stall(stall), .flush(flush), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_commit(mem_commit)
  );

  assign mem_rd_data = mem[mem_rd_addr[9:0]];

  function automatic logic [15:0] seed_word(int a);
    return 16'(a * 37 + 16'h0C00);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and protocol monitor
  always @(posedge clk) begin
    cyc++;
    if (mem_wr_en) mem[mem_wr_addr[9:0]] <= mem_wr_data;
    if (mem_rd_en && mem_wr_en) chk(1'b0, "R10 rd/wr overlap", 1, 0);
    if (mem_rd_en) begin
      rd_words++;
      if (!prev_rd && mem_rd_addr[6:0] != 7'd0)
        chk(1'b0, "R4 fill start offset", mem_rd_addr, {mem_rd_addr[15:7], 7'd0});
      if (prev_rd && mem_rd_addr != prev_rd_addr + 16'd1)
        chk(1'b0, "R4 fill order", mem_rd_addr, prev_rd_addr + 16'd1);
      if (mem_rd_addr >= 16'(MEMW)) chk(1'b0, "R4 fill range", mem_rd_addr, 0);
    end
    if (mem_wr_en) begin
      wr_words++;
      if (!prev_wr) wb_start = cyc;
      if (prev_wr && mem_wr_addr != prev_wr_addr + 16'd1)
        chk(1'b0, "R5 writeback order", mem_wr_addr, prev_wr_addr + 16'd1);
    end
    if (mem_commit) begin
      commits++;
      if (cyc - wb_start != 511) chk(1'b0, "R5 commit timing", cyc - wb_start, 511);
    end
    prev_rd = mem_rd_en;
    prev_wr = mem_wr_en;
    prev_rd_addr = mem_rd_addr;
    prev_wr_addr = mem_wr_addr;
  end

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output int stalls);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    stalls = 0;
    forever begin
      #1;
      if (!stall) break;
      @(negedge clk);
      stalls++;
    end
    rd = rdata;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic        w;
    logic [15:0] a;
    logic [15:0] d;
    logic [15:0] stalls;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0005, 16'h0000, 16'd129},  // R1 R4 first access misses
    '{1'b0, 16'h0010, 16'h0000, 16'd0},    // R2 load hit
    '{1'b1, 16'h0011, 16'hBEEF, 16'd0},    // R3 store hit
    '{1'b0, 16'h0011, 16'h0000, 16'd0},    // R3 read back
    '{1'b0, 16'h007F, 16'h0000, 16'd0},    // R9 last offset hits
    '{1'b0, 16'h0080, 16'h0000, 16'd641},  // R5 R9 dirty eviction
    '{1'b0, 16'h0000, 16'h0000, 16'd129},  // R4 clean miss
    '{1'b0, 16'h0011, 16'h0000, 16'd0},    // R5 evicted data persisted
    '{1'b1, 16'h0205, 16'h1234, 16'd129},  // R6 store miss
    '{1'b0, 16'h0205, 16'h0000, 16'd0},    // R6 patched word
    '{1'b0, 16'h0100, 16'h0000, 16'd641},  // R6 patched line was dirty
    '{1'b0, 16'h0205, 16'h0000, 16'd129}   // R6 patched word reached memory
  };

  initial begin
    logic [15:0] rd;
    int st;
    int n;
    int wr_before;
    for (int i = 0; i < MEMW; i++) begin
      mem[i] = seed_word(i);
      ref_mem[i] = seed_word(i);
    end
    rst_n = 1'b0; req = 1'b0; we = 1'b0; flush = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    chk(!busy && !stall, "R1 idle after reset", {busy, stall}, 0);
    chk(!mem_rd_en && !mem_wr_en && !mem_commit, "R1 memory quiet",
        {mem_rd_en, mem_wr_en, mem_commit}, 0);

    for (int k = 0; k < NV; k++) begin
      access(VECS[k].w, VECS[k].a, VECS[k].d, rd, st);
      chk(st == int'(VECS[k].stalls), $sformatf("R4 R5 R6 stall count row %0d", k),
          st, VECS[k].stalls);
      if (VECS[k].w) ref_mem[VECS[k].a[9:0]] = VECS[k].d;
      else chk(rd == ref_mem[VECS[k].a[9:0]], $sformatf("R2 R3 R6 load data row %0d", k),
               rd, ref_mem[VECS[k].a[9:0]]);
    end

    @(negedge clk);
    chk(rd_words == 6 * 128, "R4 total words read", rd_words, 768);
    chk(wr_words == 2 * 128, "R5 total words written", wr_words, 256);
    chk(commits == 2, "R5 commit count", commits, 2);

    // R8: flush on a clean line does nothing
    wr_before = wr_words;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk(!busy, "R8 clean flush keeps idle", busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy && wr_words == wr_before, "R8 clean flush no write", wr_words, wr_before);

    // R7: flush a dirty line
    access(1'b1, 16'h0206, 16'h7777, rd, st);
    ref_mem[16'h206] = 16'h7777;
    chk(st == 0, "R7 store hit before flush", st, 0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    n = 0;
    while (busy && n < 2000) begin n++; @(negedge clk); end
    chk(n == 512, "R7 flush busy cycles", n, 512);
    chk(commits == 3, "R7 flush commits", commits, 3);
    chk(mem[16'h206] == 16'h7777, "R7 flushed word in memory", mem[16'h206], 16'h7777);
    wr_before = wr_words;
    access(1'b0, 16'h0000, 16'h0, rd, st);
    chk(st == 129, "R7 line clean after flush", st, 129);
    chk(wr_words == wr_before, "R7 no writeback after flush", wr_words, wr_before);
    chk(rd == ref_mem[0], "R4 load after clean miss", rd, ref_mem[0]);

    // R9: both ends of the held region hit
    access(1'b0, 16'h007F, 16'h0, rd, st);
    chk(st == 0 && rd == ref_mem[16'h7F], "R9 offset 127 hit", st, 0);
    access(1'b0, 16'h0000, 16'h0, rd, st);
    chk(st == 0, "R9 offset 0 hit", st, 0);

    // R1: reset discards a dirty line
    access(1'b1, 16'h0001, 16'hAAAA, rd, st);
    do_reset();
    wr_before = wr_words;
    access(1'b0, 16'h0001, 16'h0, rd, st);
    chk(st == 129, "R1 miss after reset", st, 129);
    chk(rd == ref_mem[1], "R1 dirty data dropped", rd, ref_mem[1]);
    chk(wr_words == wr_before, "R1 no writeback after reset", wr_words, wr_before);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule